// File: doc/BRIEF.md
# Stereo Codec Serial Channel

This block serves one audio channel, left or right, of a serial stereo codec link. It has two shift paths. The receive path collects serial bits arriving from the codec's analog-to-digital converter. The transmit path sends a parallel sample out, bit by bit, to the codec's digital-to-analog converter. A shared sequencer outside the block supplies the timing. It gives a 6-bit index of the serial bit in the frame and a 2-bit phase within each serial bit period. The serial clock runs at one quarter of the master clock. A channel-active input, normally driven by the left/right selector, gates all shifting.

A controller reaches the block through a parallel host port. That port has its own select input, independent of the left/right selection. A read returns the last complete received sample. The block copies a finished sample into a holding register and flags it with a one-cycle ready pulse, so a read never returns a partly received sample. A write delivers the next sample to transmit. If a transfer is in progress, the write is parked in a buffer until the next frame starts.

Top module: `codec_lane`

## Requirements
- R1: Reset is synchronous and active low (`rst_n`). After reset, `dac_sdata` is 0, `sample_ready` is 0, a host read returns 0, and the transmit word is all zeros until the host writes one.
- R2: While `lane_active` is 1 and `phase` equals 2 with `bit_idx` below SAMPLE_W, the block shifts in `adc_sdata`. It is sent most significant bit first: the bit taken at `bit_idx` k lands at bit SAMPLE_W-1-k of the sample.
- R3: On the edge that takes the bit at `bit_idx` SAMPLE_W-1 (phase 2), the complete sample is copied to the holding register. `sample_ready` is then 1 for exactly the one following cycle.
- R4: `host_rdata` shows the held sample while both `host_sel` and `host_rd` are 1, and is all zeros otherwise. This path is combinational.
- R5: `adc_sdata` has no effect on the held sample in any of these cases: at phases other than 2, at `bit_idx` SAMPLE_W or above, or while `lane_active` is 0.
- R6: `dac_sdata` is registered and changes only on an edge where `lane_active` is 1 and `phase` is 0. After such an edge at `bit_idx` k below SAMPLE_W, it carries bit SAMPLE_W-1-k of the current word. At `bit_idx` SAMPLE_W or above, it is 0.
- R7: `dac_sdata` is 0 whenever `lane_active` is 0.
- R8: A host write made while no transfer is in progress replaces the transmit word at once. Without a new write, every later frame sends the same word again.
- R9: A transfer runs from phase 0 of `bit_idx` 0 up to the phase-2 capture at `bit_idx` SAMPLE_W-1. A host write made during that span is buffered: the running frame keeps the old word, and the buffered word is sent from the next frame start. A write on the start cycle itself is used by the frame that starts.
- R10: `host_wr` has no effect unless `host_sel` is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lane_active | input | 1 | Enables shifting for this channel |
| bit_idx | input | IDX_W (6) | Index of the serial bit in the frame, from the shared sequencer |
| phase | input | 2 | Phase within the serial bit period (0 = transmit drive, 2 = receive sample) |
| adc_sdata | input | 1 | Serial data from the converter |
| dac_sdata | output | 1 | Serial data to the converter |
| host_sel | input | 1 | Host port enable |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | SAMPLE_W (20) | Sample to transmit |
| host_rdata | output | SAMPLE_W (20) | Last complete received sample |
| sample_ready | output | 1 | One-cycle pulse when a new sample is held |

## Verification
The bench builds the block with its default parameters: SAMPLE_W of 20 and IDX_W of 6. This leaves 44 bit slots after each sample in a 64-bit frame. Those trailing slots let the bench check that the output is driven low there and that late input bits are ignored. The sample width is not a power of two, and the test words are asymmetric, so a reversed bit order or an off-by-one frame end shows up. The receive line is driven to the inverse bit on every phase other than 2, so sampling on the wrong phase corrupts the read-back sample.

// File: rtl/codec_lane_pkg.sv
// Package: codec_lane_pkg
// Shared constants and types for the codec serial channel.
// Assumes the serial bit period is four master-clock cycles.
package codec_lane_pkg;

    localparam int PHASE_W = 2;

    // Phase at which the transmit bit is updated (falling serial clock).
    localparam logic [PHASE_W-1:0] PH_DRIVE  = 2'd0;
    // Phase at which the receive bit is taken (rising serial clock).
    localparam logic [PHASE_W-1:0] PH_SAMPLE = 2'd2;

    // One-cycle event strobes decoded from the sequencer inputs.
    typedef struct packed {
        logic start;    // frame start, drive phase of bit 0
        logic tx_step;  // drive phase of a sample bit
        logic tx_tail;  // drive phase after the sample bits
        logic rx_step;  // sample phase of a sample bit
        logic rx_last;  // sample phase of the final sample bit
    } lane_strobe_t;

endpackage

// File: rtl/codec_lane_timing.sv
// Module: codec_lane_timing
// Decodes the shared sequencer's bit index and phase into per-cycle
// strobes for the transmit and receive paths, and tracks whether a
// transfer is in progress.
// Assumes SAMPLE_W <= 2**IDX_W and SAMPLE_W >= 2.
module codec_lane_timing
    import codec_lane_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lane_active,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic [PHASE_W-1:0]  phase,
    output lane_strobe_t        strb,
    output logic                busy
);

    localparam logic [IDX_W:0]   W_LIM    = (IDX_W+1)'(SAMPLE_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SAMPLE_W - 1);

    logic in_frame;

    assign in_frame = ({1'b0, bit_idx} < W_LIM);

    // Decode the event strobes for the current cycle.
    always_comb begin
        strb = '0;
        if (lane_active) begin
            if (phase == PH_DRIVE) begin
                strb.start   = (bit_idx == '0);
                strb.tx_step = in_frame;
                strb.tx_tail = !in_frame;
            end
            if (phase == PH_SAMPLE) begin
                strb.rx_step = in_frame;
                strb.rx_last = (bit_idx == LAST_IDX);
            end
        end
    end

    // Transfer-in-progress flag: set at frame start, cleared at last capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (strb.start) begin
            busy <= 1'b1;
        end else if (strb.rx_last) begin
            busy <= 1'b0;
        end
    end

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(lane_active && phase == PH_DRIVE && bit_idx == '0)); // R9

    AST_BUSY_ENDS_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_active && phase == PH_SAMPLE && bit_idx == LAST_IDX) |=> !busy); // R9

endmodule

// File: rtl/codec_lane_tx.sv
// Module: codec_lane_tx
// Transmit path: holds the word to send, rotates it out MSB first on the
// drive phase, and parks host writes made during a transfer until the
// next frame start.
// Assumes strobes come from codec_lane_timing and SAMPLE_W >= 2.
module codec_lane_tx #(
    parameter int SAMPLE_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lane_active,
    input  logic                 start,
    input  logic                 tx_step,
    input  logic                 tx_tail,
    input  logic                 busy,
    input  logic                 host_we,
    input  logic [SAMPLE_W-1:0]  host_wdata,
    output logic                 dac_sdata
);

    logic [SAMPLE_W-1:0] tx_sr;
    logic [SAMPLE_W-1:0] pend_word;
    logic                pend_v;
    logic [SAMPLE_W-1:0] src_word;
    logic                dac_q;
    logic                wr_direct;
    logic                wr_buffer;

    function automatic logic [SAMPLE_W-1:0] rotl(input logic [SAMPLE_W-1:0] v);
        return {v[SAMPLE_W-2:0], v[SAMPLE_W-1]};
    endfunction

    assign wr_direct = host_we && !busy && !start;
    assign wr_buffer = host_we &&  busy && !start;

    // Choose the word a starting frame sends: fresh write, then buffer, then current.
    always_comb begin
        if (host_we) begin
            src_word = host_wdata;
        end else if (pend_v) begin
            src_word = pend_word;
        end else begin
            src_word = tx_sr;
        end
    end

    // Transmit word register: rotates once per sent bit, back to itself after a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (start) begin
            tx_sr <= rotl(src_word);
        end else if (wr_direct) begin
            tx_sr <= host_wdata;
        end else if (tx_step) begin
            tx_sr <= rotl(tx_sr);
        end
    end

    // Write buffer for host writes arriving while a transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_word <= '0;
            pend_v    <= 1'b0;
        end else if (start || wr_direct) begin
            pend_v    <= 1'b0;
        end else if (wr_buffer) begin
            pend_word <= host_wdata;
            pend_v    <= 1'b1;
        end
    end

    // Serial output bit, updated only on the drive phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_q <= 1'b0;
        end else if (start) begin
            dac_q <= src_word[SAMPLE_W-1];
        end else if (tx_step) begin
            dac_q <= tx_sr[SAMPLE_W-1];
        end else if (tx_tail) begin
            dac_q <= 1'b0;
        end
    end

    assign dac_sdata = dac_q && lane_active;

    AST_DAC_ONLY_ON_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(start || tx_step || tx_tail) |=> $stable(dac_q)); // R6

    AST_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tail |=> !dac_q); // R6

    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !pend_v); // R9

    AST_BUSY_WRITE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && busy && !start) |=> pend_v); // R9

endmodule

// File: rtl/codec_lane_rx.sv
// Module: codec_lane_rx
// Receive path: shifts in serial bits on the sample phase, copies the
// finished sample to a holding register with a one-cycle ready pulse,
// and presents it on the host read port.
// Assumes strobes come from codec_lane_timing and SAMPLE_W >= 2.
module codec_lane_rx #(
    parameter int SAMPLE_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_step,
    input  logic                 rx_last,
    input  logic                 adc_sdata,
    input  logic                 rd_en,
    output logic [SAMPLE_W-1:0]  host_rdata,
    output logic                 sample_ready
);

    logic [SAMPLE_W-1:0] rx_sr;
    logic [SAMPLE_W-1:0] rx_hold;
    logic                ready_q;

    // Receive shift register, MSB arrives first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (rx_step) begin
            rx_sr <= {rx_sr[SAMPLE_W-2:0], adc_sdata};
        end
    end

    // Holding register and ready pulse for a complete sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_hold <= '0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= rx_last;
            if (rx_last) begin
                rx_hold <= {rx_sr[SAMPLE_W-2:0], adc_sdata};
            end
        end
    end

    assign host_rdata   = rd_en ? rx_hold : '0;
    assign sample_ready = ready_q;

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |=> !ready_q); // R3

    AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        rx_last |=> ready_q); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_q |-> $stable(rx_hold)); // R5

    AST_RX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_step |=> $stable(rx_sr)); // R5

endmodule

// File: rtl/codec_lane.sv
// Module: codec_lane
// One channel of a serial stereo codec link: receive and transmit shift
// paths timed by an external bit index and phase, with a parallel host port.
// Assumes bit_idx and phase come from a free-running shared sequencer
// (four master cycles per serial bit) and SAMPLE_W <= 2**IDX_W.
module codec_lane
    import codec_lane_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int IDX_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lane_active,
    input  logic [IDX_W-1:0]     bit_idx,
    input  logic [1:0]           phase,
    input  logic                 adc_sdata,
    output logic                 dac_sdata,
    input  logic                 host_sel,
    input  logic                 host_rd,
    input  logic                 host_wr,
    input  logic [SAMPLE_W-1:0]  host_wdata,
    output logic [SAMPLE_W-1:0]  host_rdata,
    output logic                 sample_ready
);

    lane_strobe_t strb;
    logic         busy;
    logic         host_we;
    logic         rd_en;

    assign host_we = host_sel && host_wr;
    assign rd_en   = host_sel && host_rd;

    codec_lane_timing #(
        .SAMPLE_W (SAMPLE_W),
        .IDX_W    (IDX_W)
    ) u_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .lane_active (lane_active),
        .bit_idx     (bit_idx),
        .phase       (phase),
        .strb        (strb),
        .busy        (busy)
    );

    codec_lane_tx #(
        .SAMPLE_W (SAMPLE_W)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .lane_active (lane_active),
        .start       (strb.start),
        .tx_step     (strb.tx_step),
        .tx_tail     (strb.tx_tail),
        .busy        (busy),
        .host_we     (host_we),
        .host_wdata  (host_wdata),
        .dac_sdata   (dac_sdata)
    );

    codec_lane_rx #(
        .SAMPLE_W (SAMPLE_W)
    ) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_step      (strb.rx_step),
        .rx_last      (strb.rx_last),
        .adc_sdata    (adc_sdata),
        .rd_en        (rd_en),
        .host_rdata   (host_rdata),
        .sample_ready (sample_ready)
    );

    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(lane_active) && !lane_active |-> !dac_sdata); // R7

    AST_WR_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel |-> !host_we); // R10

endmodule

// File: tb/test_codec_lane.sv
// Bench for codec_lane: a vector table of receive/transmit word pairs
// walked by one loop, then directed tests for reset and corner cases.
module test_codec_lane;

    localparam int W  = 20;
    localparam int IW = 6;
    localparam int FRAME_BITS = 64;

    // Each entry: {received word driven on adc_sdata, word written for transmit}
    localparam logic [2*W-1:0] VEC [0:3] = '{
        40'hFFFFF_00001,
        40'h00001_80000,
        40'h5A5A5_FFFFF,
        40'hA5C3F_3C0F1
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lane_active = 1'b0;
    logic [IW-1:0] bit_idx = '0;
    logic [1:0]    phase = '0;
    logic          adc_sdata = 1'b0;
    logic          dac_sdata;
    logic          host_sel = 1'b0;
    logic          host_rd = 1'b0;
    logic          host_wr = 1'b0;
    logic [W-1:0]  host_wdata = '0;
    logic [W-1:0]  host_rdata;
    logic          sample_ready;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    codec_lane #(.SAMPLE_W(W), .IDX_W(IW)) i_codec_lane (
        .clk          (clk),
        .rst_n        (rst_n),
        .lane_active  (lane_active),
        .bit_idx      (bit_idx),
        .phase        (phase),
        .adc_sdata    (adc_sdata),
        .dac_sdata    (dac_sdata),
        .host_sel     (host_sel),
        .host_rd      (host_rd),
        .host_wr      (host_wr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .sample_ready (sample_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_read(input bit sel, output logic [W-1:0] val);
        host_sel = sel;
        host_rd  = 1'b1;
        #1;
        val = host_rdata;
        host_sel = 1'b0;
        host_rd  = 1'b0;
    endtask

    task automatic host_write_idle(input logic [W-1:0] w);
        lane_active = 1'b0;
        host_sel    = 1'b1;
        host_wr     = 1'b1;
        host_wdata  = w;
        @(negedge clk);
        host_sel    = 1'b0;
        host_wr     = 1'b0;
    endtask

    // One 64-bit frame; optional host write at (wr_idx, wr_ph).
    // adc_sdata carries the true bit only on phase 2, its inverse otherwise.
    task automatic run_frame(input logic [W-1:0] adc_w, input bit act,
                             input int wr_idx, input int wr_ph, input logic [W-1:0] wr_w,
                             output logic [W-1:0] dac_seen, output int rdy_cnt,
                             output int tail_bad, output int idle_bad);
        dac_seen = '0;
        rdy_cnt  = 0;
        tail_bad = 0;
        idle_bad = 0;
        for (int idx = 0; idx < FRAME_BITS; idx++) begin
            for (int ph = 0; ph < 4; ph++) begin
                logic b;
                b = (idx < W) ? adc_w[W-1-idx] : idx[0];
                bit_idx     = IW'(idx);
                phase       = 2'(ph);
                lane_active = act;
                adc_sdata   = (ph == 2) ? b : ~b;
                host_sel    = (idx == wr_idx) && (ph == wr_ph);
                host_wr     = (idx == wr_idx) && (ph == wr_ph);
                host_wdata  = wr_w;
                @(negedge clk);
                host_sel = 1'b0;
                host_wr  = 1'b0;
                if (act && ph == 0 && idx < W) dac_seen[W-1-idx] = dac_sdata;
                if (act && ph == 0 && idx >= W && dac_sdata) tail_bad++;
                if (!act && dac_sdata) idle_bad++;
                if (sample_ready) rdy_cnt++;
            end
        end
        lane_active = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] rd;
        logic [W-1:0] seen;
        int rdy, tb, ib;

        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1 dac after reset", 32'(dac_sdata), 32'h0);
        chk("R1 ready after reset", 32'(sample_ready), 32'h0);
        host_read(1'b1, rd);
        chk("R1 read after reset", 32'(rd), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: write transmit word while idle, run a frame, check both paths.
        for (int i = 0; i < 4; i++) begin
            logic [W-1:0] adc_w, dac_w;
            adc_w = VEC[i][2*W-1:W];
            dac_w = VEC[i][W-1:0];
            host_write_idle(dac_w);
            run_frame(adc_w, 1'b1, -1, 0, '0, seen, rdy, tb, ib);
            chk("R6 R8 transmitted word", 32'(seen), 32'(dac_w));
            chk("R3 one ready pulse", 32'(rdy), 32'd1);
            chk("R6 tail bits low", 32'(tb), 32'd0);
            host_read(1'b1, rd);
            chk("R2 R4 R5 received word", 32'(rd), 32'(adc_w));
        end

        // R8: no new write, the same word is sent again.
        run_frame(20'h12345, 1'b1, -1, 0, '0, seen, rdy, tb, ib);
        chk("R8 resend", 32'(seen), 32'h3C0F1);
        host_read(1'b1, rd);
        chk("R2 second sample", 32'(rd), 32'h12345);

        // R9: write during a transfer is buffered for the next frame.
        run_frame(20'h0ABCD, 1'b1, 5, 1, 20'h0F0F0, seen, rdy, tb, ib);
        chk("R9 running frame keeps old word", 32'(seen), 32'h3C0F1);
        run_frame(20'h0ABCD, 1'b1, -1, 0, '0, seen, rdy, tb, ib);
        chk("R9 buffered word sent next", 32'(seen), 32'h0F0F0);

        // R9: write on the start cycle goes out in that frame.
        run_frame(20'h0ABCD, 1'b1, 0, 0, 20'hC0003, seen, rdy, tb, ib);
        chk("R9 start-cycle write", 32'(seen), 32'hC0003);

        // R10: write strobe without select is ignored.
        host_sel   = 1'b0;
        host_wr    = 1'b1;
        host_wdata = 20'h11111;
        @(negedge clk);
        host_wr    = 1'b0;
        run_frame(20'h0ABCD, 1'b1, -1, 0, '0, seen, rdy, tb, ib);
        chk("R10 unselected write ignored", 32'(seen), 32'hC0003);
        // R4: read strobe without select gives zero.
        host_read(1'b0, rd);
        chk("R4 unselected read", 32'(rd), 32'h0);

        // R7 and R5: inactive frame leaves line low and held sample unchanged.
        run_frame(20'hFFFFF, 1'b0, -1, 0, '0, seen, rdy, tb, ib);
        chk("R7 line low while inactive", 32'(ib), 32'd0);
        chk("R5 no ready while inactive", 32'(rdy), 32'd0);
        host_read(1'b1, rd);
        chk("R5 held sample unchanged", 32'(rd), 32'h0ABCD);

        // R1: reset after traffic clears held sample and transmit word.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 dac after second reset", 32'(dac_sdata), 32'h0);
        host_read(1'b1, rd);
        chk("R1 read after second reset", 32'(rd), 32'h0);
        run_frame(20'h00000, 1'b1, -1, 0, '0, seen, rdy, tb, ib);
        chk("R1 transmit word cleared", 32'(seen), 32'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule